// File: doc/BRIEF.md
# Door Status Scanner over a Single Serial Line

The block reports the open or closed state of eight doors to eight indicator LEDs at a remote post using one shared status wire. A free-running scan counter picks one door per clock; a selector turns that door's contact into a single serial bit; a distributor at the far end uses the same counter value to send the bit to the LED with the same index. A closed door keeps its LED dark. An open door lights its LED for one clock out of every eight, so the LED flashes. Since the scan runs at 20 Hz, each open-door LED flashes at 2.5 Hz.

The scan value and the serial bit are captured together in one register stage. The LED drivers are decoded from that stage and never from a path that is still settling, so an LED that is not selected never sees a short low pulse. All LED outputs are active low. A synchronous active-high reset returns the scanner to slot 0 and turns every LED off.

Top module: `door_scan_top`

## Requirements
- R1: While reset is high at a clock edge, the scanner goes to slot 0 (`scan_sel` = 0), `line_bit` = 0, and every bit of `led_n` = 1 (all LEDs dark) after that edge.
- R2: Out of reset, `scan_sel` moves up by one on every clock edge and wraps from 7 to 0.
- R3: After each edge taken out of reset, `line_bit` equals the `door_open` bit (1 = open, 0 = closed) whose index was on `scan_sel` just before that edge.
- R4: After each edge taken out of reset, the LED whose index was on `scan_sel` before that edge is low exactly when `line_bit` is 1.
- R5: If the door being scanned is closed (`door_open` bit = 0), all `led_n` bits are 1 after the edge.
- R6: No more than one bit of `led_n` is low at any time.
- R7: With the door inputs held steady, the LED of an open door is low for exactly 1 clock in each run of 8 consecutive clocks. The LED of a closed door is never low.
- R8: The number of low `led_n` bits equals `line_bit`. LEDs that are not selected stay at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock (20 Hz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| door_open | input | 8 | Door contacts, bit i = 1 when door i is open |
| scan_sel | output | 3 | Current scan slot, shared by the selector and the distributor |
| line_bit | output | 1 | Registered serial status bit on the shared wire |
| led_n | output | 8 | Active-low LED drives, bit i for door i |

## Verification
The assertions assume that `door_open` is synchronous to `clk` and does not change close to the rising edge. They also assume that reset is a clean synchronous level. Under those assumptions, the bit sampled through the selector is the same bit that was on the input before the edge. The stimulus changes the door inputs and reset only on the falling edge of the clock, so every sample point sees settled values. The stimulus covers several kinds of door patterns: all closed, all open, a single open door walking across the inputs, pseudo-random patterns that change every cycle, and a steady pattern held long enough to count flashes.

// File: rtl/door_scan_pkg.sv
package door_scan_pkg;

    localparam int DOOR_COUNT = 8;
    localparam int SEL_W      = (DOOR_COUNT > 1) ? $clog2(DOOR_COUNT) : 1;
    localparam int LAST_SLOT  = DOOR_COUNT - 1;
    localparam bit FULL_RANGE = (DOOR_COUNT == (1 << SEL_W));

    typedef logic [SEL_W-1:0]      sel_t;
    typedef logic [DOOR_COUNT-1:0] door_vec_t;

    // one beat on the shared wire: the slot it belongs to and its status
    typedef struct packed {
        sel_t slot;
        logic open;
    } beat_t;

    localparam beat_t BEAT_IDLE = '{slot: '0, open: 1'b0};

    function automatic sel_t slot_after(sel_t cur);
        if (cur == sel_t'(LAST_SLOT))
            return '0;
        return sel_t'(cur + 1'b1);
    endfunction

endpackage

// File: rtl/dscan_counter.sv
module dscan_counter
    import door_scan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output sel_t slot
);

    sel_t slot_q;
    sel_t slot_d;

    generate
        if (FULL_RANGE) begin : g_natural_wrap
            always_comb slot_d = sel_t'(slot_q + 1'b1);
        end else begin : g_compare_wrap
            always_comb slot_d = slot_after(slot_q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else
            slot_q <= slot_d;
    end

    assign slot = slot_q;

    // R2: the last slot is followed by slot 0
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_q == sel_t'(LAST_SLOT)) |=> (slot_q == '0));

    // R2: every other slot is followed by the next one
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_q != sel_t'(LAST_SLOT)) |=> (slot_q == sel_t'($past(slot_q) + 1'b1)));

endmodule

// File: rtl/dscan_mux.sv
module dscan_mux
    import door_scan_pkg::*;
(
    input  door_vec_t doors,
    input  sel_t      slot,
    output logic      serial
);

    always_comb begin
        serial = 1'b0;
        for (int i = 0; i < DOOR_COUNT; i++) begin
            if (slot == sel_t'(i))
                serial = doors[i];
        end
    end

endmodule

// File: rtl/dscan_line.sv
module dscan_line
    import door_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sel_t  slot,
    input  logic  serial,
    output beat_t beat
);

    beat_t beat_q;

    // slot and status bit are captured on the same edge so that the
    // distributor never decodes a slot that has not yet settled
    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= BEAT_IDLE;
        else
            beat_q <= '{slot: slot, open: serial};
    end

    assign beat = beat_q;

endmodule

// File: rtl/dscan_demux.sv
module dscan_demux
    import door_scan_pkg::*;
(
    input  beat_t     beat,
    output door_vec_t led_n
);

    generate
        for (genvar g = 0; g < DOOR_COUNT; g++) begin : g_lamp
            assign led_n[g] = !(beat.open && (beat.slot == sel_t'(g)));
        end
    endgenerate

endmodule

// File: rtl/door_scan_top.sv
module door_scan_top
    import door_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] door_open,
    output logic [2:0] scan_sel,
    output logic       line_bit,
    output logic [7:0] led_n
);

    sel_t      slot;
    logic      serial;
    beat_t     beat;
    door_vec_t lamps_n;

    dscan_counter u_counter (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    dscan_mux u_mux (
        .doors  (door_open),
        .slot   (slot),
        .serial (serial)
    );

    dscan_line u_line (
        .clk    (clk),
        .rst    (rst),
        .slot   (slot),
        .serial (serial),
        .beat   (beat)
    );

    dscan_demux u_demux (
        .beat  (beat),
        .led_n (lamps_n)
    );

    assign scan_sel = slot;
    assign line_bit = beat.open;
    assign led_n    = lamps_n;

    // R3: the wire carries the door picked by the previous slot
    p_sample_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (line_bit == $past(door_open[scan_sel])));

    // R4: the LED with the previous slot's index follows the wire
    p_route_r4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (led_n[$past(scan_sel)] == !line_bit));

    // R5: a closed door being scanned leaves every LED dark
    p_closed_r5: assert property (@(posedge clk) disable iff (rst)
        (!rst && !door_open[scan_sel]) |=> (&led_n));

    // R6: no more than one LED lit
    p_single_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~led_n));

    // R8: lit LED count matches the wire
    p_agree_r8: assert property (@(posedge clk) disable iff (rst)
        ($countones(~led_n) == 32'(line_bit)));

endmodule

// File: tb/door_scan_top_test.sv
module door_scan_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] door_open = 8'h00;
    logic [2:0] scan_sel;
    logic       line_bit;
    logic [7:0] led_n;

    door_scan_top uut (
        .clk       (clk),
        .rst       (rst),
        .door_open (door_open),
        .scan_sel  (scan_sel),
        .line_bit  (line_bit),
        .led_n     (led_n)
    );

    always #2 clk = ~clk;

    int   errors = 0;
    int   checks = 0;
    bit   done   = 1'b0;
    int   m_cnt  = 0;
    int   m_sel  = 0;
    logic m_bit  = 1'b0;
    int   lit_count [8];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: update the reference at the edge, compare at the falling edge
    task automatic tick();
        logic [7:0] exp_led;
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_sel = 0; m_bit = 1'b0;
        end else begin
            m_sel = m_cnt;
            m_bit = door_open[m_cnt];
            m_cnt = (m_cnt + 1) % 8;
        end
        @(negedge clk);
        exp_led = 8'hFF;
        if (m_bit) exp_led[m_sel] = 1'b0;
        check(int'(scan_sel) == m_cnt, "R2", "scan_sel", scan_sel, m_cnt);
        check(line_bit == m_bit, "R3", "line_bit", line_bit, m_bit);
        check(led_n == exp_led, "R4/R8", "led_n", led_n, exp_led);
        check($countones(~led_n) <= 1, "R6", "lit count", $countones(~led_n), 1);
        for (int i = 0; i < 8; i++)
            if (!led_n[i]) lit_count[i]++;
    endtask

    task automatic reset_check();
        check(scan_sel == 3'd0, "R1", "scan_sel after reset", scan_sel, 0);
        check(line_bit == 1'b0, "R1", "line_bit after reset", line_bit, 0);
        check(led_n == 8'hFF, "R1", "led_n after reset", led_n, 8'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        // R1: reset state
        rst = 1'b1;
        tick(); tick();
        reset_check();
        @(negedge clk) ;
        rst = 1'b0;

        // R5: all doors closed, LEDs stay dark
        door_open = 8'h00;
        for (int c = 0; c < 16; c++) begin
            tick();
            check(led_n == 8'hFF, "R5", "closed doors led_n", led_n, 8'hFF);
        end

        // all doors open
        door_open = 8'hFF;
        for (int c = 0; c < 16; c++) tick();

        // single open door walking across the inputs
        for (int d = 0; d < 8; d++) begin
            door_open = 8'h01 << d;
            for (int c = 0; c < 11; c++) tick();
        end

        // pseudo-random patterns changing every cycle
        lfsr = 8'h5B;
        for (int c = 0; c < 200; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            door_open = lfsr;
            tick();
        end

        // R7: steady pattern, count flashes over four scan rounds
        door_open = 8'hA6;
        for (int c = 0; c < 8; c++) tick();
        for (int i = 0; i < 8; i++) lit_count[i] = 0;
        for (int c = 0; c < 32; c++) tick();
        for (int i = 0; i < 8; i++) begin
            if (door_open[i])
                check(lit_count[i] == 4, "R7", $sformatf("open LED %0d flashes", i),
                      lit_count[i], 4);
            else
                check(lit_count[i] == 0, "R5", $sformatf("closed LED %0d flashes", i),
                      lit_count[i], 0);
        end

        // R1: reset in the middle of a scan
        door_open = 8'hFF;
        for (int c = 0; c < 5; c++) tick();
        rst = 1'b1;
        tick();
        reset_check();
        rst = 1'b0;
        for (int c = 0; c < 20; c++) tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule